// File: doc/BRIEF.md
# Strobed BCD Seven-Segment Digit Latch

This block holds the segment patterns for four seven-segment digits that share one 4-bit code bus. Each digit has its own active-high strobe. The strobes come from an asynchronous source, so each one first passes through a two-flop synchroniser. A rising strobe then makes a load pulse one clock wide. That pulse writes the decoded glyph of the current code into the digit's 7-bit segment register.

A strobe that stays high keeps its digit live. Each transition of the external backplane toggle input, in either direction, makes a fresh load pulse for every digit whose strobe is high. A digit whose strobe is low keeps its pattern unchanged.

The decoder holds two fonts, chosen by a single select input:
- A hexadecimal font.
- An alternate font with dash, E, H, L and P glyphs and a blank code.

The 28 registered segment bits are meant for an external display driver.

Top module: `segstrobe_latch`

## Requirements
- R1: While the reset is held and after it is released, before any load, all 28 bits of `seg_o` are 0. A 0 means unlit.
- R2: Bits `seg_o[7k+6:7k]` belong to digit k, and `strobe_i[k]` is that digit's strobe. Within a digit, bit 0 is segment a, then b, c, d, e, f, and bit 6 is segment g; a 1 means lit. A rising edge on `strobe_i[k]` loads the glyph of `code_i` under `font_sel_i` into digit k. The new pattern is visible no later than the third rising clock edge after the strobe is sampled high, and the internal load pulse lasts exactly one clock.
- R3: While `strobe_i[k]` stays high, each transition of `bp_i`, rising or falling, reloads digit k with the glyph of the present `code_i` and `font_sel_i`. A change of `code_i` with no strobe edge and no backplane transition leaves the digit unchanged.
- R4: While `strobe_i[k]` is low, digit k keeps its pattern whatever `code_i`, `font_sel_i` and `bp_i` do.
- R5: When several strobes rise together (all four included), every selected digit receives the same glyph and every unselected digit is unchanged.
- R6: Codes 0 to 9 give the same pattern in both fonts. The lit segments are:
  - 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg, 4 = bcfg
  - 5 = acdfg, 6 = acdefg, 7 = abc, 8 = all seven, 9 = abcdfg
- R7: With `font_sel_i` = 0 (hex font), the codes above 9 light these segments:
  - 10 shows A = abcefg, 11 shows b = cdefg, 12 shows C = adef
  - 13 shows d = bcdeg, 14 shows E = adefg, 15 shows F = aefg
- R8: With `font_sel_i` = 1 (alternate font), the codes above 9 light these segments:
  - 10 shows a dash = g, 11 shows E = adefg, 12 shows H = bcefg
  - 13 shows L = def, 14 shows P = abefg
  - 15 lights nothing (blank)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_i | input | 4 | Shared 4-bit character code |
| strobe_i | input | 4 | Per-digit active-high strobes; bit k selects digit k |
| font_sel_i | input | 1 | Font select: 0 = hex font, 1 = alternate font |
| bp_i | input | 1 | Backplane toggle; each transition refreshes digits whose strobe is high |
| seg_o | output | 28 | Registered segment bits, 7 per digit, bit 0 = segment a |

## Verification
The assertions assume two things about the inputs:
- `code_i` and `font_sel_i` are steady during any cycle in which a load pulse can occur, that is, while a strobe is high or shortly after it rises.
- `bp_i` does not toggle faster than the synchroniser can follow.

The stimulus meets both assumptions. It changes the code and font only while every strobe is low, or in deliberate refresh tests. In those tests it holds a strobe high, changes the code, waits several clocks, and only then toggles `bp_i`. Each strobe or backplane event is followed by at least four idle clocks before any output is compared.

// File: rtl/segstrobe_pkg.sv
package segstrobe_pkg;
  localparam int SEG_W = 7;

  typedef enum logic {
    FONT_HEX = 1'b0,
    FONT_ALT = 1'b1
  } font_e;

  // segment bit positions inside one digit
  localparam int SEG_A = 0;
  localparam int SEG_B = 1;
  localparam int SEG_C = 2;
  localparam int SEG_D = 3;
  localparam int SEG_E = 4;
  localparam int SEG_F = 5;
  localparam int SEG_G = 6;

  function automatic logic [SEG_W-1:0] seg_mask(input bit a, input bit b, input bit c,
                                                input bit d, input bit e, input bit f,
                                                input bit g);
    logic [SEG_W-1:0] m;
    m        = '0;
    m[SEG_A] = a;
    m[SEG_B] = b;
    m[SEG_C] = c;
    m[SEG_D] = d;
    m[SEG_E] = e;
    m[SEG_F] = f;
    m[SEG_G] = g;
    return m;
  endfunction
endpackage

// File: rtl/segstrobe_rst_sync.sv
module segstrobe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/segstrobe_sync.sv
module segstrobe_sync #(
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] async_i,
  output logic [LANES-1:0] lvl_o,
  output logic [LANES-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DEPTH-1:0] sh_q;
    logic [DEPTH-1:0] sh_d;

    always_comb begin
      sh_d = {sh_q[DEPTH-2:0], async_i[l]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
      end else begin
        sh_q <= sh_d;
      end
    end

    assign lvl_o[l]  = sh_q[STAGES-1];
    assign prev_o[l] = sh_q[STAGES];
  end
endmodule

// File: rtl/segstrobe_glyph.sv
module segstrobe_glyph
  import segstrobe_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code_i,
  input  font_e             font_i,
  output logic [SEG_W-1:0]  glyph_o
);
  logic [SEG_W-1:0] numeral;
  logic [SEG_W-1:0] hex_hi;
  logic [SEG_W-1:0] alt_hi;

  always_comb begin
    unique case (code_i[3:0])
      4'd0:    numeral = seg_mask(1, 1, 1, 1, 1, 1, 0);
      4'd1:    numeral = seg_mask(0, 1, 1, 0, 0, 0, 0);
      4'd2:    numeral = seg_mask(1, 1, 0, 1, 1, 0, 1);
      4'd3:    numeral = seg_mask(1, 1, 1, 1, 0, 0, 1);
      4'd4:    numeral = seg_mask(0, 1, 1, 0, 0, 1, 1);
      4'd5:    numeral = seg_mask(1, 0, 1, 1, 0, 1, 1);
      4'd6:    numeral = seg_mask(1, 0, 1, 1, 1, 1, 1);
      4'd7:    numeral = seg_mask(1, 1, 1, 0, 0, 0, 0);
      4'd8:    numeral = seg_mask(1, 1, 1, 1, 1, 1, 1);
      4'd9:    numeral = seg_mask(1, 1, 1, 1, 0, 1, 1);
      default: numeral = '0;
    endcase
  end

  always_comb begin
    unique case (code_i[3:0])
      4'd10:   hex_hi = seg_mask(1, 1, 1, 0, 1, 1, 1);
      4'd11:   hex_hi = seg_mask(0, 0, 1, 1, 1, 1, 1);
      4'd12:   hex_hi = seg_mask(1, 0, 0, 1, 1, 1, 0);
      4'd13:   hex_hi = seg_mask(0, 1, 1, 1, 1, 0, 1);
      4'd14:   hex_hi = seg_mask(1, 0, 0, 1, 1, 1, 1);
      4'd15:   hex_hi = seg_mask(1, 0, 0, 0, 1, 1, 1);
      default: hex_hi = '0;
    endcase
  end

  always_comb begin
    unique case (code_i[3:0])
      4'd10:   alt_hi = seg_mask(0, 0, 0, 0, 0, 0, 1);
      4'd11:   alt_hi = seg_mask(1, 0, 0, 1, 1, 1, 1);
      4'd12:   alt_hi = seg_mask(0, 1, 1, 0, 1, 1, 1);
      4'd13:   alt_hi = seg_mask(0, 0, 0, 1, 1, 1, 0);
      4'd14:   alt_hi = seg_mask(1, 1, 0, 0, 1, 1, 1);
      default: alt_hi = '0;
    endcase
  end

  always_comb begin
    if (code_i[3:0] < 4'd10) begin
      glyph_o = numeral;
    end else if (font_i == FONT_ALT) begin
      glyph_o = alt_hi;
    end else begin
      glyph_o = hex_hi;
    end
  end
endmodule

// File: rtl/segstrobe_digit.sv
module segstrobe_digit #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] glyph_i,
  output logic [W-1:0] seg_o
);
  logic [W-1:0] seg_q;
  logic [W-1:0] seg_d;

  always_comb begin
    seg_d = seg_q;
    if (load_i) begin
      seg_d = glyph_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
    end else begin
      seg_q <= seg_d;
    end
  end

  assign seg_o = seg_q;
endmodule

// File: rtl/segstrobe_latch.sv
module segstrobe_latch
  import segstrobe_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CODE_W-1:0]        code_i,
  input  logic [DIGITS-1:0]        strobe_i,
  input  logic                     font_sel_i,
  input  logic                     bp_i,
  output logic [DIGITS*SEG_W-1:0]  seg_o
);
  localparam int OUT_W = DIGITS * SEG_W;

  logic              rst_n_s;
  logic [DIGITS-1:0] strobe_lvl;
  logic [DIGITS-1:0] strobe_prev;
  logic [0:0]        bp_lvl;
  logic [0:0]        bp_prev;
  logic              bp_tog;
  logic [DIGITS-1:0] strobe_rise;
  logic [DIGITS-1:0] load;
  logic [SEG_W-1:0]  glyph;
  font_e             font;

  segstrobe_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  segstrobe_sync #(.LANES(DIGITS), .STAGES(SYNC_STAGES)) u_strobe_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i (strobe_i),
    .lvl_o   (strobe_lvl),
    .prev_o  (strobe_prev)
  );

  segstrobe_sync #(.LANES(1), .STAGES(SYNC_STAGES)) u_bp_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i (bp_i),
    .lvl_o   (bp_lvl),
    .prev_o  (bp_prev)
  );

  assign bp_tog = bp_lvl[0] ^ bp_prev[0];
  assign font   = font_e'(font_sel_i);

  segstrobe_glyph #(.CODE_W(CODE_W)) u_glyph (
    .code_i  (code_i),
    .font_i  (font),
    .glyph_o (glyph)
  );

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    assign strobe_rise[k] = strobe_lvl[k] & ~strobe_prev[k];
    assign load[k]        = strobe_rise[k] | (strobe_lvl[k] & bp_tog);

    segstrobe_digit #(.W(SEG_W)) u_digit (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .load_i  (load[k]),
      .glyph_i (glyph),
      .seg_o   (seg_o[k*SEG_W +: SEG_W])
    );
  end

  logic [OUT_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/segstrobe_latch_chk.sv
module segstrobe_latch_chk
  import segstrobe_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int CODE_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [DIGITS-1:0]       strobe_lvl,
  input logic [DIGITS-1:0]       strobe_rise,
  input logic                    bp_tog,
  input logic [DIGITS-1:0]       load,
  input logic [SEG_W-1:0]        glyph,
  input logic [CODE_W-1:0]       code_i,
  input logic                    font_sel_i,
  input logic [DIGITS*SEG_W-1:0] seg_o
);
  // R8: the alternate font blanks code 15
  assert_alt_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (font_sel_i && code_i == 4'hF) |-> (glyph == '0));

  for (genvar k = 0; k < DIGITS; k++) begin : g_chk
    // R2: a load pulse writes the decoded glyph into the digit
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load[k] |=> (seg_o[k*SEG_W +: SEG_W] == $past(glyph)));

    // R2: a strobe rise gives a single-clock pulse when no refresh follows
    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_rise[k] && !bp_tog) |=> !strobe_rise[k]);

    // R3: backplane toggle with strobe held reloads the digit
    assert_refresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_tog && strobe_lvl[k]) |-> load[k]);

    // R4: without a load the digit is stable
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !load[k] |=> $stable(seg_o[k*SEG_W +: SEG_W]));

    // R4: loads only while the synchronised strobe is high
    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load[k] |-> strobe_lvl[k]);
  end
endmodule

bind segstrobe_latch segstrobe_latch_chk #(.DIGITS(DIGITS), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .strobe_lvl  (strobe_lvl),
  .strobe_rise (strobe_rise),
  .bp_tog      (bp_tog),
  .load        (load),
  .glyph       (glyph),
  .code_i      (code_i),
  .font_sel_i  (font_sel_i),
  .seg_o       (seg_o)
);

// File: tb/segstrobe_latch_tb.sv
module segstrobe_latch_tb;
  logic        clk;
  logic        rst_n;
  logic [3:0]  code_i;
  logic [3:0]  strobe_i;
  logic        font_sel_i;
  logic        bp_i;
  logic [27:0] seg_o;

  int unsigned n_chk;
  int unsigned n_fail;
  logic [6:0]  model [4];
  bit          done;

  segstrobe_latch u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_i     (code_i),
    .strobe_i   (strobe_i),
    .font_sel_i (font_sel_i),
    .bp_i       (bp_i),
    .seg_o      (seg_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // lit segment bits: bit0 = a ... bit6 = g
  function automatic logic [6:0] exp_glyph(input logic [3:0] c, input logic alt);
    case (c)
      4'd0:  return 7'b0111111;
      4'd1:  return 7'b0000110;
      4'd2:  return 7'b1011011;
      4'd3:  return 7'b1001111;
      4'd4:  return 7'b1100110;
      4'd5:  return 7'b1101101;
      4'd6:  return 7'b1111101;
      4'd7:  return 7'b0000111;
      4'd8:  return 7'b1111111;
      4'd9:  return 7'b1101111;
      4'd10: return alt ? 7'b1000000 : 7'b1110111;
      4'd11: return alt ? 7'b1111001 : 7'b1111100;
      4'd12: return alt ? 7'b1110110 : 7'b0111001;
      4'd13: return alt ? 7'b0111000 : 7'b1011110;
      4'd14: return alt ? 7'b1110011 : 7'b1111001;
      default: return alt ? 7'b0000000 : 7'b1110001;
    endcase
  endfunction

  function automatic logic [27:0] model_vec();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  task automatic check(input string req, input logic [27:0] exp);
    n_chk++;
    if (seg_o !== exp) begin
      n_fail++;
      $display("FAIL %s: seg_o actual %h expected %h", req, seg_o, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // strobe the digits in mask with code/font, then release
  task automatic write_digits(input logic [3:0] mask, input logic [3:0] c, input logic alt);
    @(negedge clk);
    code_i     = c;
    font_sel_i = alt;
    strobe_i   = mask;
    idle(5);
    strobe_i = 4'b0000;
    idle(4);
    for (int k = 0; k < 4; k++) if (mask[k]) model[k] = exp_glyph(c, alt);
  endtask

  initial begin
    int unsigned cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    n_chk      = 0;
    n_fail     = 0;
    done       = 0;
    rst_n      = 1'b0;
    code_i     = 4'd0;
    strobe_i   = 4'd0;
    font_sel_i = 1'b0;
    bp_i       = 1'b0;
    for (int k = 0; k < 4; k++) model[k] = 7'd0;
    seed_dummy = $urandom(32'd1234);

    idle(4);
    check("R1 in reset", 28'd0);
    rst_n = 1'b1;
    idle(6);
    check("R1 after reset", 28'd0);

    // R2: single digits
    write_digits(4'b0001, 4'd2, 1'b0);
    check("R2 digit0 code2", model_vec());
    write_digits(4'b1000, 4'd7, 1'b1);
    check("R2 digit3 code7", model_vec());

    // R5: all strobes together, then a pair
    write_digits(4'b1111, 4'd8, 1'b0);
    check("R5 all digits code8", model_vec());
    write_digits(4'b0110, 4'd3, 1'b1);
    check("R5 two digits code3", model_vec());

    // R6/R7/R8: every code in both fonts on digit 1
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 2; f++) begin
        write_digits(4'b0010, 4'(c), 1'(f));
        if (c < 10)      check("R6 numeral", model_vec());
        else if (f == 0) check("R7 hex font", model_vec());
        else             check("R8 alt font", model_vec());
      end
    end

    // R3: hold strobe on digit 2, change code, no bp toggle -> no change
    @(negedge clk);
    code_i = 4'd5; font_sel_i = 1'b0; strobe_i = 4'b0100;
    idle(5);
    model[2] = exp_glyph(4'd5, 1'b0);
    check("R3 held strobe loaded", model_vec());
    code_i = 4'd12; font_sel_i = 1'b1;
    idle(6);
    check("R3 code change without bp keeps digit", model_vec());
    bp_i = ~bp_i;
    idle(5);
    model[2] = exp_glyph(4'd12, 1'b1);
    check("R3 bp rise refresh", model_vec());
    code_i = 4'd9;
    idle(4);
    bp_i = ~bp_i;
    idle(5);
    model[2] = exp_glyph(4'd9, 1'b1);
    check("R3 bp fall refresh", model_vec());
    strobe_i = 4'b0000;
    idle(4);

    // R4: strobes low, code/font/bp activity ignored
    for (int i = 0; i < 6; i++) begin
      code_i = 4'($urandom_range(0, 15));
      font_sel_i = 1'($urandom_range(0, 1));
      idle(2);
      bp_i = ~bp_i;
      idle(4);
      check("R4 hold with strobes low", model_vec());
    end

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [3:0] m;
      m = 4'($urandom_range(0, 15));
      write_digits(m, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
      if (m == 4'd0)                check("R4 random no strobe", model_vec());
      else if ($countones(m) > 1)   check("R5 random multi", model_vec());
      else                          check("R2 random single", model_vec());
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule